// File: doc/BRIEF.md
# Dual-divisor FSK tag waveform generator

This block drives the coil of a low-frequency tag emulator. It produces a repeating bit stream that carries a 44-bit identifier as frequency-shift keying. Each bit is built from two sub-patterns, one with a period of 8 carrier cycles and one with a period of 10. Each rising edge of an external carrier-clock input moves the stream on by one sample. A 1 sample opens the coil and a 0 sample shorts it.

Every frame has three parts, sent in this order:
- a single 8-sample short unit as a preamble;
- a start marker made of symbols arranged so that they break the bit encoding;
- 44 data bits, with one 8-sample separator in front of each group of four bits.

The frame repeats with no gap. Software pulses `start` to latch the identifier and begin the stream. It pulses `stop` to end the stream, which leaves the coil open.

Top module: `fsk_tag_emulator`

## Requirements
- R1: After reset, and whenever the stream is not running, `coil_out` is 1 (coil open), including across carrier edges.
- R2: A carrier rising edge is a cycle in which `carrier_in` is 1 and was 0 in the previous cycle. The stream advances exactly one sample per carrier rising edge. `coil_out` is registered: it takes the new sample in the clock cycle after the edge is sampled, and it never changes when there is no edge. Holding `carrier_in` high advances the stream only once.
- R3: The first 8 samples of every frame are 1,1,0,0,0,0,0,0.
- R4: A short symbol (S) is the unit 1,1,0,0,0,0,0,0 repeated 6 times, which is 48 samples. A long symbol (L) is the unit 1,1,1,0,0,0,0,0,0,0 repeated 5 times, which is 50 samples.
- R5: The preamble is followed by the start marker, which is the symbols S,S,S,L,L,L,S,L in that order.
- R6: The identifier bits follow the marker, sent from bit 43 down to bit 0. A 1 bit is L then S. A 0 bit is S then L.
- R7: A single 8-sample unit 1,1,0,0,0,0,0,0 is placed before each bit whose index mod 4 is 3, that is before bits 43, 39, …, 3.
- R8: A frame is 4800 samples long. Sample 0 of the next frame follows sample 4799 directly.
- R9: `id_in` is captured when `start` is accepted in the idle state. Changes on `id_in` have no effect while the stream is running, and neither has a `start` pulse while the stream is running.
- R10: After `stop` is pulsed during a run, the next carrier edge sets `coil_out` to 1 and halts the stream. Until that edge, the output holds its value. Later edges keep `coil_out` at 1. The next `start` begins again at sample 0 of the frame. A `stop` pulse in the idle state has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_in | input | 1 | Carrier clock, synchronous to clk; each rising edge is one sample step |
| id_in | input | 44 | Identifier to transmit |
| start | input | 1 | Pulse to latch the identifier and begin the stream when idle |
| stop | input | 1 | Pulse to end the stream at the next carrier edge |
| coil_out | output | 1 | Coil level: 1 open, 0 shorted |

## Verification
Four identifiers are streamed through whole frames, and every sample is compared with an arithmetic model of the frame:
- all zeros and all ones, which isolate the S-then-L and L-then-S bit orders;
- alternating bits, which exercise every symbol boundary between bits;
- an irregular value, which exposes bit-order or group-position errors that the symmetric values hide.

One run continues past the wrap point, which checks the frame length. Other checks cover:
- holding the carrier high, to show that only a rising edge moves the stream;
- changing the identifier and pulsing `start` in the middle of a run, to show that the captured identifier is held;
- a `stop` that arrives between edges, which must wait for the next edge;
- restarting after a stop, which must begin again at the preamble.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    EL_SEP   = 2'd0,
    EL_SHORT = 2'd1,
    EL_LONG  = 2'd2
  } elem_e;

  typedef enum logic [1:0] {
    SEG_PRE  = 2'd0,
    SEG_MARK = 2'd1,
    SEG_SEP  = 2'd2,
    SEG_BIT  = 2'd3
  } seg_e;
endpackage

// File: rtl/fsk_unit_gen.sv
module fsk_unit_gen
  import fsk_pkg::*;
#(
  parameter int SHORT_LEN  = 8,
  parameter int SHORT_HIGH = 2,
  parameter int SHORT_REPS = 6,
  parameter int LONG_LEN   = 10,
  parameter int LONG_HIGH  = 3,
  parameter int LONG_REPS  = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  logic  step,
  input  elem_e kind,
  output logic  sample,
  output logic  elem_last
);
  localparam int MAXLEN  = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int MAXREPS = (LONG_REPS > SHORT_REPS) ? LONG_REPS : SHORT_REPS;
  localparam int PW = $clog2(MAXLEN);
  localparam int RW = $clog2(MAXREPS + 1);

  logic [PW-1:0] pos;
  logic [RW-1:0] rep;
  logic [PW-1:0] len_m1;
  logic [PW-1:0] high_n;
  logic [RW-1:0] reps_m1;

  always_comb begin
    unique case (kind)
      EL_LONG: begin
        len_m1  = PW'(LONG_LEN - 1);
        high_n  = PW'(LONG_HIGH);
        reps_m1 = RW'(LONG_REPS - 1);
      end
      EL_SHORT: begin
        len_m1  = PW'(SHORT_LEN - 1);
        high_n  = PW'(SHORT_HIGH);
        reps_m1 = RW'(SHORT_REPS - 1);
      end
      default: begin
        len_m1  = PW'(SHORT_LEN - 1);
        high_n  = PW'(SHORT_HIGH);
        reps_m1 = '0;
      end
    endcase
    sample    = (pos < high_n);
    elem_last = (pos == len_m1) && (rep == reps_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pos <= '0;
      rep <= '0;
    end else if (step) begin
      if (pos == len_m1) begin
        pos <= '0;
        rep <= elem_last ? '0 : rep + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  // R4: position inside a unit and repetition count stay within the current symbol
  assert_pos_range_R4: assert property (@(posedge clk) disable iff (rst)
    (pos <= len_m1) && (rep <= reps_m1));
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_pkg::*;
#(
  parameter int ID_W     = 44,
  parameter int GROUP    = 4,
  parameter int MARK_LEN = 8,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 8'b1011_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            advance,
  input  logic [ID_W-1:0] id,
  output elem_e           kind
);
  localparam int MW = (MARK_LEN > 1) ? $clog2(MARK_LEN) : 1;
  localparam int BW = $clog2(ID_W);
  localparam int GW = $clog2(GROUP);

  seg_e          seg;
  logic [MW-1:0] midx;
  logic [BW-1:0] bidx;
  logic          half;

  function automatic logic grp_head(input logic [BW-1:0] b);
    return b[GW-1:0] == {GW{1'b1}};
  endfunction

  always_comb begin
    unique case (seg)
      SEG_MARK: kind = MARK_PAT[midx] ? EL_LONG : EL_SHORT;
      SEG_BIT:  kind = (id[bidx] ^ half) ? EL_LONG : EL_SHORT;
      default:  kind = EL_SEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      seg  <= SEG_PRE;
      midx <= '0;
      bidx <= BW'(ID_W - 1);
      half <= 1'b0;
    end else if (advance) begin
      unique case (seg)
        SEG_PRE: begin
          seg  <= SEG_MARK;
          midx <= '0;
        end
        SEG_MARK: begin
          if (midx == MW'(MARK_LEN - 1)) begin
            seg <= grp_head(BW'(ID_W - 1)) ? SEG_SEP : SEG_BIT;
          end else begin
            midx <= midx + 1'b1;
          end
        end
        SEG_SEP: begin
          seg  <= SEG_BIT;
          half <= 1'b0;
        end
        SEG_BIT: begin
          if (!half) begin
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            if (bidx == '0) begin
              seg  <= SEG_PRE;
              bidx <= BW'(ID_W - 1);
            end else begin
              bidx <= bidx - 1'b1;
              seg  <= grp_head(bidx - 1'b1) ? SEG_SEP : SEG_BIT;
            end
          end
        end
      endcase
    end
  end

  // R6: bit index stays inside the identifier
  assert_bit_range_R6: assert property (@(posedge clk) disable iff (rst)
    bidx <= BW'(ID_W - 1));
  // R6: the second half of a bit only exists in the data segment
  assert_half_R6: assert property (@(posedge clk) disable iff (rst)
    (seg != SEG_BIT) |-> !half);
  // R5: the marker index stays within the marker
  assert_mark_range_R5: assert property (@(posedge clk) disable iff (rst)
    midx <= MW'(MARK_LEN - 1));
endmodule

// File: rtl/fsk_tag_emulator.sv
module fsk_tag_emulator
  import fsk_pkg::*;
#(
  parameter int ID_W       = 44,
  parameter int GROUP      = 4,
  parameter int MARK_LEN   = 8,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 8'b1011_1000,
  parameter int SHORT_LEN  = 8,
  parameter int SHORT_HIGH = 2,
  parameter int SHORT_REPS = 6,
  parameter int LONG_LEN   = 10,
  parameter int LONG_HIGH  = 3,
  parameter int LONG_REPS  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            carrier_in,
  input  logic [ID_W-1:0] id_in,
  input  logic            start,
  input  logic            stop,
  output logic            coil_out
);
  logic            car_q;
  logic            running;
  logic            stop_pend;
  logic [ID_W-1:0] id_r;
  logic            coil_r;

  logic  car_edge;
  logic  restart;
  logic  stop_now;
  logic  step;
  logic  sample;
  logic  elem_last;
  elem_e kind;

  assign car_edge = carrier_in & ~car_q;
  assign restart  = start & ~running;
  assign stop_now = stop | stop_pend;
  assign step     = running & car_edge & ~stop_now;
  assign coil_out = coil_r;

  fsk_frame_seq #(
    .ID_W(ID_W), .GROUP(GROUP), .MARK_LEN(MARK_LEN), .MARK_PAT(MARK_PAT)
  ) u_seq (
    .clk(clk), .rst(rst), .restart(restart),
    .advance(step & elem_last), .id(id_r), .kind(kind)
  );

  fsk_unit_gen #(
    .SHORT_LEN(SHORT_LEN), .SHORT_HIGH(SHORT_HIGH), .SHORT_REPS(SHORT_REPS),
    .LONG_LEN(LONG_LEN), .LONG_HIGH(LONG_HIGH), .LONG_REPS(LONG_REPS)
  ) u_unit (
    .clk(clk), .rst(rst), .restart(restart), .step(step),
    .kind(kind), .sample(sample), .elem_last(elem_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q     <= 1'b0;
      running   <= 1'b0;
      stop_pend <= 1'b0;
      id_r      <= '0;
      coil_r    <= 1'b1;
    end else begin
      car_q <= carrier_in;
      if (restart) begin
        running   <= 1'b1;
        id_r      <= id_in;
        stop_pend <= 1'b0;
      end else if (running) begin
        if (car_edge) begin
          if (stop_now) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
            coil_r    <= 1'b1;
          end else begin
            coil_r <= sample;
          end
        end else if (stop) begin
          stop_pend <= 1'b1;
        end
      end
    end
  end

  // R1: coil open whenever idle
  assert_idle_open_R1: assert property (@(posedge clk) disable iff (rst)
    !running |-> coil_r);
  // R2: output moves only after a carrier rising edge
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !car_edge |=> $stable(coil_r));
  // R10: a stop seen at an edge halts with the coil open
  assert_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (running && car_edge && stop_now) |=> (!running && coil_r));
  // R9: captured identifier is held while running
  assert_id_hold_R9: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(id_r));
endmodule

// File: tb/fsk_tag_emulator_test.sv
`timescale 1ns/1ps
module fsk_tag_emulator_test;
  localparam int FRAME = 8 + 4*48 + 4*50 + 11*8 + 44*(48+50);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        carrier_in = 1'b0;
  logic [43:0] id_in = '0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        coil_out;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic [43:0] cur_id;
  logic        last_exp;

  int mark_seq [8] = '{0, 0, 0, 1, 1, 1, 0, 1};

  always #2.5 clk = ~clk;

  fsk_tag_emulator uut (
    .clk(clk), .rst(rst), .carrier_in(carrier_in), .id_in(id_in),
    .start(start), .stop(stop), .coil_out(coil_out)
  );

  function automatic logic sym_sample(input logic lg, input int off);
    return lg ? ((off % 10) < 3) : ((off % 8) < 2);
  endfunction

  function automatic logic model(input logic [43:0] id, input int n_in, output string tag);
    int n = n_in;
    int len;
    logic lg;
    tag = "R3";
    if (n < 8) return n < 2;
    n -= 8;
    tag = "R5 R4";
    for (int i = 0; i < 8; i++) begin
      lg = (mark_seq[i] != 0);
      len = lg ? 50 : 48;
      if (n < len) return sym_sample(lg, n);
      n -= len;
    end
    for (int b = 43; b >= 0; b--) begin
      if ((b % 4) == 3) begin
        tag = "R7";
        if (n < 8) return n < 2;
        n -= 8;
      end
      tag = "R6 R4";
      for (int h = 0; h < 2; h++) begin
        lg = id[b] ^ (h == 1);
        len = lg ? 50 : 48;
        if (n < len) return sym_sample(lg, n);
        n -= len;
      end
    end
    tag = "R8";
    return 1'b1;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag, input int idx);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s sample %0d got %b expected %b", tag, idx, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) carrier_in = 1'b1;
    @(negedge clk) carrier_in = 1'b0;
  endtask

  task automatic begin_run(input logic [43:0] id);
    @(negedge clk);
    id_in = id;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur_id = id;
    k = 0;
  endtask

  task automatic run(input int count);
    string tag;
    logic e;
    for (int i = 0; i < count; i++) begin
      tick();
      e = model(cur_id, k % FRAME, tag);
      if (k >= FRAME) tag = "R8";
      chk(coil_out, e, tag, k);
      last_exp = e;
      k++;
    end
  endtask

  task automatic halt_and_check();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    repeat (3) @(negedge clk);
    chk(coil_out, last_exp, "R10 waiting for edge", k);
    tick();
    chk(coil_out, 1'b1, "R10 stop edge", k);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(coil_out, 1'b1, "R10 halted", k);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(coil_out, 1'b1, "R1 reset", 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(coil_out, 1'b1, "R1 idle edge", i);
    end
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;

    // all zeros, then wrap into the second frame
    begin_run(44'h0);
    run(FRAME + 120);
    halt_and_check();

    // all ones; restart must begin at sample 0
    begin_run(44'hFFF_FFFF_FFFF);
    run(FRAME);
    halt_and_check();

    // alternating bits
    begin_run(44'hAAA_AAAA_AAAA);
    run(FRAME);
    halt_and_check();

    // irregular value with mid-run disturbances
    begin_run(44'h59C_3E1B_72D4);
    run(1000);
    @(negedge clk);
    id_in = ~id_in;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run(500);
    // carrier held high advances only once
    begin
      string tag;
      logic e;
      @(negedge clk) carrier_in = 1'b1;
      @(negedge clk);
      e = model(cur_id, k, tag);
      chk(coil_out, e, "R2 held high first", k);
      repeat (4) @(negedge clk);
      chk(coil_out, e, "R2 held high stable", k);
      carrier_in = 1'b0;
      last_exp = e;
      k++;
    end
    run(FRAME - k + 60);
    chk(coil_out, last_exp, "R9 R8 captured id kept", k);
    halt_and_check();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule